// File: doc/BRIEF.md
# I2C/SMBus Register-Access Slave

This block is the slave end of a two-wire serial bus. It takes the clock line and the data line from an open-drain bus and turns bus transactions into accesses on a 16-entry register-file port. It recognises start, repeated start and stop conditions and matches a 7-bit slave address. A command byte then sets an internal register pointer. Data bytes are written to the register file or read from it at that pointer, and the pointer steps by one after each byte.

Plain writes, plain reads, combined-format reads and SMBus-style block transfers are all supported. A combined-format read is a write of the command byte, then a repeated start, then a read. In block mode the byte that follows the command is a declared length. The slave acknowledges that byte and then discards it. The length of the transfer comes only from the bytes actually moved: a write ends at the stop condition, and a read ends when the master answers a byte with NACK. Both lines pass through two-flop synchronisers. The slave only ever pulls the data line low, through an output enable.

The controller is one enumerated state machine. `ST_IDLE` waits for a start. `ST_ADDR` shifts in the address byte and moves to `ST_ADDR_ACK` on a match, or to `ST_IGNORE` on a mismatch. `ST_ADDR_ACK` moves to `ST_RDATA` for a read or to `ST_CMD` for a write. `ST_CMD` moves to `ST_CMD_ACK` when the top bit is 1, otherwise to `ST_IGNORE`. `ST_CMD_ACK` moves to `ST_COUNT` in block mode, otherwise to `ST_WDATA`. `ST_COUNT` goes to `ST_COUNT_ACK`, which goes on to `ST_WDATA`. `ST_WDATA` and `ST_WDATA_ACK` alternate for as long as bytes arrive. `ST_RDATA` goes to `ST_RACK` after eight bits. `ST_RACK` returns to `ST_RDATA` on the master's ACK, or goes to `ST_IGNORE` on NACK. From any state, a start goes to `ST_ADDR` and a stop goes to `ST_IDLE`.

Top module: `smb_reg_slave`

## Requirements
- R1: A start condition (data falling while the clock is high) returns the slave to address reception with a cleared bit count, from any state and at any bit position. A stop condition (data rising while the clock is high) returns it to idle with the data line released.
- R2: The first byte after a start carries the 7-bit address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). The slave acknowledges it, by driving 0 in the ninth clock, only when bits 7:1 equal the parameter `SLAVE_ADDR`. On a mismatch the slave leaves the data line released for every later bit until the next start.
- R3: In a write, the first byte after the address is a command only if its bit 7 is 1. A command is acknowledged and its bits 3:0 become the register pointer. A byte whose bit 7 is 0 gets a NACK, and the rest of the transaction is ignored, with no register written.
- R4: Bit 4 of the command byte selects block mode. In block mode the next written byte is a count: it is acknowledged, never written to a register, and does not move the pointer.
- R5: Each written data byte is acknowledged and is presented on the register port at the current pointer with a one-cycle write strobe. The pointer then steps by one and wraps from 15 to 0.
- R6: In a read, the slave sends the register at the pointer, most significant bit first, and steps the pointer after each byte. It sends the next byte while the master acknowledges. After a NACK it releases the data line until the next start or stop.
- R7: The pointer set in the write phase carries across a repeated start, or across a stop, into the following read.
- R8: The slave drives the data line only by pulling it low through `sda_oe`. `sda_oe` changes only in the cycle after a detected clock fall, start or stop, so it never changes while the clock line is high.
- R9: In a block write, the number of registers written equals the number of data bytes sent before the stop, whatever the count byte says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| reg_addr | output | PTR_W | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle strobe when read data is captured |
| reg_rdata | input | 8 | Register file read data at `reg_addr` (combinational) |

## Verification
The assertions check the cycle-level rules on every cycle. They check that the output enable moves only after a clock fall or a bus condition, that every start re-arms address reception and every stop releases the line, that the acknowledge states are reached only with a matching address or a flagged command, that reads happen only in read direction, and that the pointer steps after each write strobe. The bench's scenarios show what depends on whole transactions. It sweeps all 128 addresses, and it runs combined reads from every pointer with wrap-around. It also checks block writes with a misleading count byte, the pointer carrying across repeated start and stop, aborts in the middle of a byte, and the released line after a NACK. In each case the register contents and the received bytes are compared with a model kept in the bench.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W       = 8;
    localparam int CNT_W        = 4;
    localparam int CMD_FLAG_BIT = 7;
    localparam int BLOCK_BIT    = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Reset to the idle level of an open-drain bus line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '1;
        end else begin
            sr <= {sr[STAGES-2:0], d};
        end
    end

    assign q = sr[STAGES-1];

    initial begin
        AST_SYNC_DEPTH: assert (STAGES >= 2); // R8
    end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // Data edges count as bus conditions only while the clock stays high.
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h39,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int LINES = 2;

    // ---------------- line synchronisers and bus events ----------------
    logic [LINES-1:0] line_raw, line_s;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign line_raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (line_raw[g]),
            .q     (line_s[g])
        );
    end

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    smb_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // ---------------- state and datapath registers ----------------
    smb_state_e        state, state_n;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic [CNT_W-1:0]  cnt;
    logic [PTR_W-1:0]  ptr;
    logic              rw, blk, more;

    logic rx_state, byte_done, addr_hit, load_tx, tx_last;

    assign rx_state  = (state == ST_ADDR) || (state == ST_CMD) ||
                       (state == ST_COUNT) || (state == ST_WDATA);
    assign byte_done = rx_state && scl_fall && (cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (shreg[BYTE_W-1:1] == SLAVE_ADDR);
    assign load_tx   = scl_fall && (((state == ST_ADDR_ACK) && rw) ||
                                    ((state == ST_RACK) && more));
    assign tx_last   = (state == ST_RDATA) && scl_fall &&
                       (cnt == CNT_W'(BYTE_W - 1));

    // Next-state logic
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_n = state;
                ST_ADDR:      if (byte_done) state_n = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)  state_n = rw ? ST_RDATA : ST_CMD;
                ST_CMD:       if (byte_done) state_n = shreg[CMD_FLAG_BIT] ? ST_CMD_ACK : ST_IGNORE;
                ST_CMD_ACK:   if (scl_fall)  state_n = blk ? ST_COUNT : ST_WDATA;
                ST_COUNT:     if (byte_done) state_n = ST_COUNT_ACK;
                ST_COUNT_ACK: if (scl_fall)  state_n = ST_WDATA;
                ST_WDATA:     if (byte_done) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_n = ST_WDATA;
                ST_RDATA:     if (tx_last)   state_n = ST_RACK;
                ST_RACK:      if (scl_fall)  state_n = more ? ST_RDATA : ST_IGNORE;
                default:                     state_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Datapath: shift register, bit counter, pointer, transmit byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            tx    <= '0;
            cnt   <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            blk   <= 1'b0;
            more  <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else begin
            if (rx_state && scl_rise) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
                cnt   <= cnt + 1'b1;
            end
            if (byte_done) begin
                cnt <= '0;
            end
            if (byte_done && (state == ST_ADDR) && addr_hit) begin
                rw <= shreg[0];
            end
            if (byte_done && (state == ST_CMD) && shreg[CMD_FLAG_BIT]) begin
                ptr <= shreg[PTR_W-1:0];
                blk <= shreg[BLOCK_BIT];
            end
            if (byte_done && (state == ST_WDATA)) begin
                ptr <= ptr + 1'b1;
            end
            if (load_tx) begin
                tx <= reg_rdata;
            end
            if ((state == ST_RDATA) && scl_fall) begin
                if (tx_last) begin
                    cnt <= '0;
                    ptr <= ptr + 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                    tx  <= {tx[BYTE_W-2:0], 1'b0};
                end
            end
            if ((state == ST_RACK) && scl_rise) begin
                more <= ~sda_s;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                                           sda_oe = ~tx[BYTE_W-1];
            default:                                            sda_oe = 1'b0;
        endcase
    end

    assign reg_addr  = ptr;
    assign reg_wdata = shreg;
    assign reg_we    = byte_done && (state == ST_WDATA);
    assign reg_re    = load_tx;

    // ---------------- assertions ----------------
    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R8

    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> ((state == ST_ADDR) && (cnt == '0))); // R1

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> ((state == ST_IDLE) && !sda_oe)); // R1

    AST_ACK_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[BYTE_W-1:1] == SLAVE_ADDR)); // R2

    AST_CMD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD_ACK) |-> shreg[CMD_FLAG_BIT]); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_we) |-> (reg_addr == PTR_W'($past(reg_addr) + 1'b1))); // R5

    AST_READ_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA) |-> rw); // R6
endmodule

// File: tb/sim_smb_reg_slave.sv
`timescale 1ns/1ps
module sim_smb_reg_slave;
    localparam logic [6:0] SLV = 7'h39;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic m_scl, m_low;
    logic sda_bus;
    logic sda_oe, reg_we, reg_re;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] mem [16];
    logic [7:0] exp_mem [16];

    int vec = 0;
    int bad = 0;
    int oe_bad = 0;
    bit done = 0;
    logic prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = !(m_low || sda_oe);

    smb_reg_slave #(.SLAVE_ADDR(SLV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // Register file behind the port
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = mem[reg_addr];

    // R8 monitor: the enable must not move while the clock line is high
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && m_scl) oe_bad++;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_low = 1'b1; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_low = 1'b0; wait_q();
    endtask

    task automatic send_bit(input bit b);
        m_low = !b; wait_q();
        m_scl = 1'b1; wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output bit b);
        m_low = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        b = sda_bus; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic write_byte(input logic [7:0] v, output bit acked);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = !b;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(!give_ack);
    endtask

    task automatic compare_mem(input string req);
        for (int i = 0; i < 16; i++) chk(mem[i] === exp_mem[i], req, mem[i], exp_mem[i]);
    endtask

    task automatic do_write(input int p, input bit blk, input int n,
                            input logic [7:0] base, input logic [7:0] step, input string req);
        bit a;
        logic [7:0] v;
        bus_start();
        write_byte({SLV, 1'b0}, a); chk(a, "R2 address ack", a, 1);
        write_byte(8'h80 | (blk ? 8'h10 : 8'h00) | 8'(p & 15), a); chk(a, "R3 command ack", a, 1);
        if (blk) begin
            write_byte(8'h02, a); chk(a, "R4 count byte ack", a, 1);
        end
        for (int i = 0; i < n; i++) begin
            v = 8'(base + i * step);
            write_byte(v, a); chk(a, req, a, 1);
            exp_mem[(p + i) % 16] = v;
        end
        bus_stop();
        compare_mem(req);
    endtask

    task automatic do_comb_read(input int p, input bit blk, input int n, input string req);
        bit a;
        logic [7:0] v;
        bus_start();
        write_byte({SLV, 1'b0}, a); chk(a, "R2 address ack", a, 1);
        write_byte(8'h80 | (blk ? 8'h10 : 8'h00) | 8'(p & 15), a); chk(a, "R3 command ack", a, 1);
        bus_start();
        write_byte({SLV, 1'b1}, a); chk(a, "R7 read address ack after repeated start", a, 1);
        for (int i = 0; i < n; i++) begin
            read_byte(v, i != n - 1);
            chk(v === exp_mem[(p + i) % 16], req, v, exp_mem[(p + i) % 16]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit a;
        bit b;
        logic [7:0] v;
        m_scl = 1'b1; m_low = 1'b0; rst_n = 1'b0;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R8 reset line released", sda_oe, 0);
        chk(reg_we == 1'b0, "R1 reset no write", reg_we, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2: address sweep, write direction
        for (int ad = 0; ad < 128; ad++) begin
            bus_start();
            write_byte({7'(ad), 1'b0}, a);
            chk(a == (7'(ad) == SLV), "R2 address match", a, 7'(ad) == SLV);
            if (7'(ad) != SLV) begin
                write_byte(8'h80, a);
                chk(!a, "R2 silent after mismatch", a, 0);
            end
            bus_stop();
        end
        // R2: mismatched read leaves line released
        bus_start();
        write_byte({SLV ^ 7'h01, 1'b1}, a); chk(!a, "R2 read mismatch nack", a, 0);
        read_byte(v, 1'b0); chk(v == 8'hFF, "R2 no drive after mismatch", v, 8'hFF);
        bus_stop();

        // R3: non-command byte
        bus_start();
        write_byte({SLV, 1'b0}, a); chk(a, "R2 address ack", a, 1);
        write_byte(8'h05, a); chk(!a, "R3 flag clear nack", a, 0);
        write_byte(8'hAA, a); chk(!a, "R3 rest ignored", a, 0);
        bus_stop();
        compare_mem("R3 no write after non-command");

        // R5: fill all registers, then wrap
        do_write(0, 1'b0, 16, 8'h05, 8'd37, "R5 sequential write");
        do_write(14, 1'b0, 4, 8'hC0, 8'd1, "R5 pointer wrap write");

        // R7: combined reads from every pointer
        for (int k = 0; k < 16; k++) do_comb_read(k, 1'b0, 3, "R7 combined read data");

        // R6: plain read continues where the last read left off (15+3 -> 2)
        bus_start();
        write_byte({SLV, 1'b1}, a); chk(a, "R6 read address ack", a, 1);
        read_byte(v, 1'b1); chk(v === exp_mem[2], "R6 pointer continues", v, exp_mem[2]);
        read_byte(v, 1'b0); chk(v === exp_mem[3], "R6 streamed byte", v, exp_mem[3]);
        recv_bit(b); chk(b == 1'b1, "R6 released after NACK", b, 1);
        bus_stop();

        // R4 / R9: block write with misleading count
        do_write(6, 1'b1, 5, 8'h50, 8'd1, "R9 block write length");
        chk(mem[6] == 8'h50, "R4 count byte discarded", mem[6], 8'h50);
        do_comb_read(9, 1'b1, 4, "R4 block combined read");

        // R1: start in the middle of the address byte
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        write_byte({SLV, 1'b0}, a); chk(a, "R1 restart mid-byte", a, 1);
        write_byte(8'h83, a); chk(a, "R3 command ack", a, 1);
        bus_stop();
        // R7: pointer kept across a stop
        bus_start();
        write_byte({SLV, 1'b1}, a); chk(a, "R1 address after stop", a, 1);
        read_byte(v, 1'b0); chk(v === exp_mem[3], "R7 pointer across stop", v, exp_mem[3]);
        bus_stop();
        // R1: stop in the middle of a byte, then a clean transfer
        bus_start();
        send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        bus_start();
        write_byte({SLV, 1'b1}, a); chk(a, "R1 recover after mid-byte stop", a, 1);
        read_byte(v, 1'b0); chk(v === exp_mem[4], "R6 read after recovery", v, exp_mem[4]);
        bus_stop();

        chk(oe_bad == 0, "R8 enable stable while clock high", oe_bad, 0);
        finish_run();
    end
endmodule